// File: doc/BRIEF.md
# Flag-Based Magnitude Comparator

This block orders two operands of a parameterised width. A single ripple subtractor forms the difference op_b minus op_a as op_b plus the inverted op_a plus a forced carry-in of one. From that one difference it derives five condition flags: carry out, zero, negative, overflow and the true sign. The ordering results for the selected number mode are decoded from those flags. No separate comparator circuit is used.

The block is purely combinational and has no clock or reset. A caller drives both operands and the mode bit. When mode is 0 the operands are compared as unsigned numbers; when it is 1 they are compared as two's-complement numbers. The outputs are the raw flag bits and three mutually exclusive results, which state whether op_a is below, equal to or above op_b. The five flags do not depend on the mode bit. Only the three decoded results change with it.

Top module: `flag_magcmp`

## Requirements
- R1: flag_c is the carry out of the full-width sum op_b + ~op_a + 1; it is 1 exactly when op_a <= op_b as unsigned values.
- R2: flag_z is 1 exactly when every bit of the difference is 0, that is when op_a equals op_b.
- R3: flag_n equals bit W-1 of (op_b - op_a) taken modulo 2^W.
- R4: flag_v is 1 exactly when op_a[W-1] differs from op_b[W-1] and bit W-1 of the difference differs from op_b[W-1].
- R5: flag_s equals flag_n XOR flag_v, and it is 1 exactly when op_b < op_a as two's-complement values.
- R6: With signed_mode = 0, a_lt_b is 1 exactly when op_a < op_b unsigned, and a_gt_b is 1 exactly when op_a > op_b unsigned (that is, when flag_c = 0).
- R7: With signed_mode = 1, a_gt_b is 1 exactly when op_a > op_b signed (that is, when flag_s = 1), and a_lt_b is 1 exactly when op_a < op_b signed.
- R8: In both modes a_eq_b equals flag_z, and exactly one of a_lt_b, a_eq_b and a_gt_b is 1 for every defined input.
- R9: signed_mode has no effect on any of the five flags; for the same operands they are identical in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | Subtrahend operand |
| op_b | input | W | Minuend operand |
| signed_mode | input | 1 | 1 = two's-complement ordering, 0 = unsigned ordering |
| flag_c | output | 1 | Carry out of the subtraction |
| flag_z | output | 1 | Difference is all zeros |
| flag_n | output | 1 | Most significant bit of the difference |
| flag_v | output | 1 | Signed overflow of the subtraction |
| flag_s | output | 1 | True sign of the signed difference (N XOR V) |
| a_lt_b | output | 1 | op_a below op_b in the selected mode |
| a_eq_b | output | 1 | op_a equal to op_b |
| a_gt_b | output | 1 | op_a above op_b in the selected mode |

## Verification
The assertions are checked every time the inputs settle. They check the relations between the flags and the decoded results: exactly one result is asserted, equality follows flag_z, the sign flag is the XOR of N and V, and the decode matches the mode's reading of the flags. Whether the flags hold the correct arithmetic meaning can only be shown by the bench. It sweeps every operand pair in both modes and compares each output against independent signed and unsigned reference comparisons. The sweep covers the boundary pairs at zero, the most negative value and all ones, and it shows that the flags stay the same when only the mode changes.

// File: rtl/flag_magcmp_pkg.sv
package flag_magcmp_pkg;
  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
    logic s;
  } cmp_flags_t;
endpackage

// File: rtl/magcmp_subtract.sv
module magcmp_subtract #(
  parameter int W = 8
) (
  input  logic [W-1:0] minuend,
  input  logic [W-1:0] subtrahend,
  output logic [W-1:0] diff,
  output logic         carry_out
);
  logic [W:0]   cy;
  logic [W-1:0] inv_sub;

  assign inv_sub = ~subtrahend;
  assign cy[0]   = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic half;
    assign half      = minuend[i] ^ inv_sub[i];
    assign diff[i]   = half ^ cy[i];
    assign cy[i+1]   = (minuend[i] & inv_sub[i]) | (cy[i] & half);
  end

  assign carry_out = cy[W];
endmodule

// File: rtl/magcmp_flags.sv
module magcmp_flags
  import flag_magcmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] diff,
  input  logic         carry_out,
  input  logic         sign_a,
  input  logic         sign_b,
  output cmp_flags_t   flags
);
  localparam int MSB = W - 1;

  always_comb begin
    flags.c = carry_out;
    flags.z = ~|diff;
    flags.n = diff[MSB];
    flags.v = (sign_a ^ sign_b) & (diff[MSB] ^ sign_b);
    flags.s = flags.n ^ flags.v;
  end
endmodule

// File: rtl/magcmp_decode.sv
module magcmp_decode
  import flag_magcmp_pkg::*;
(
  input  cmp_flags_t flags,
  input  logic       signed_mode,
  output logic       lt,
  output logic       eq,
  output logic       gt
);
  logic b_below_a;

  always_comb begin
    b_below_a = signed_mode ? flags.s : ~flags.c;
    eq        = flags.z;
    gt        = b_below_a;
    lt        = ~b_below_a & ~flags.z;
  end
endmodule

// File: rtl/flag_magcmp.sv
module flag_magcmp
  import flag_magcmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         signed_mode,
  output logic         flag_c,
  output logic         flag_z,
  output logic         flag_n,
  output logic         flag_v,
  output logic         flag_s,
  output logic         a_lt_b,
  output logic         a_eq_b,
  output logic         a_gt_b
);
  localparam int MSB = W - 1;

  logic [W-1:0] diff;
  logic         carry_out;
  cmp_flags_t   flags;

  magcmp_subtract #(.W(W)) u_sub (
    .minuend    (op_b),
    .subtrahend (op_a),
    .diff       (diff),
    .carry_out  (carry_out)
  );

  magcmp_flags #(.W(W)) u_flags (
    .diff      (diff),
    .carry_out (carry_out),
    .sign_a    (op_a[MSB]),
    .sign_b    (op_b[MSB]),
    .flags     (flags)
  );

  magcmp_decode u_dec (
    .flags       (flags),
    .signed_mode (signed_mode),
    .lt          (a_lt_b),
    .eq          (a_eq_b),
    .gt          (a_gt_b)
  );

  assign flag_c = flags.c;
  assign flag_z = flags.z;
  assign flag_n = flags.n;
  assign flag_v = flags.v;
  assign flag_s = flags.s;
endmodule

// File: rtl/flag_magcmp_chk.sv
module flag_magcmp_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         signed_mode,
  input logic         flag_c,
  input logic         flag_z,
  input logic         flag_n,
  input logic         flag_v,
  input logic         flag_s,
  input logic         a_lt_b,
  input logic         a_eq_b,
  input logic         a_gt_b
);
  always_comb begin
    p_one_result_r8: assert ($countones({a_lt_b, a_eq_b, a_gt_b}) == 1);
    p_eq_is_zero_r8: assert (a_eq_b == flag_z);
    p_zero_means_equal_r2: assert (flag_z == (op_a == op_b));
    p_sign_xor_r5: assert (flag_s == (flag_n ^ flag_v));
    p_unsigned_gt_r6: assert (signed_mode || (a_gt_b == ~flag_c));
    p_signed_gt_r7: assert (!signed_mode || (a_gt_b == flag_s));
    p_no_overflow_same_sign_r4: assert ((op_a[W-1] != op_b[W-1]) || !flag_v);
    p_equal_carries_r1: assert (!flag_z || flag_c);
  end
endmodule

bind flag_magcmp flag_magcmp_chk #(.W(W)) u_chk (.*);

// File: tb/test_flag_magcmp.sv
module test_flag_magcmp;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic signed_mode = 1'b0;
  logic flag_c, flag_z, flag_n, flag_v, flag_s, a_lt_b, a_eq_b, a_gt_b;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_magcmp #(.W(W)) i_flag_magcmp (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= WATCHDOG_CYCLES && !done) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual %0d cycles, expected under %0d", cycles, WATCHDOG_CYCLES);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp, inout bit bad);
    if (act !== exp) begin
      bad = 1'b1;
      $display("FAIL %s a=%0d b=%0d m=%0d: actual %b expected %b", req, op_a, op_b, signed_mode, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic m);
    logic [W-1:0] d;
    logic ec, ez, en, ev, es, elt, egt;
    bit bad;
    @(posedge clk);
    op_a = a; op_b = b; signed_mode = m;
    @(negedge clk);
    d   = b - a;
    ec  = (b >= a);
    ez  = (a == b);
    en  = d[W-1];
    ev  = (a[W-1] != b[W-1]) && (d[W-1] != b[W-1]);
    es  = ($signed(b) < $signed(a));
    elt = m ? ($signed(a) < $signed(b)) : ($unsigned(a) < $unsigned(b));
    egt = m ? ($signed(a) > $signed(b)) : ($unsigned(a) > $unsigned(b));
    bad = 1'b0;
    chk("R1 flag_c", flag_c, ec, bad);
    chk("R2 flag_z", flag_z, ez, bad);
    chk("R3 flag_n", flag_n, en, bad);
    chk("R4 flag_v", flag_v, ev, bad);
    chk("R5 flag_s", flag_s, es, bad);
    chk(m ? "R7 a_lt_b" : "R6 a_lt_b", a_lt_b, elt, bad);
    chk(m ? "R7 a_gt_b" : "R6 a_gt_b", a_gt_b, egt, bad);
    chk("R8 a_eq_b", a_eq_b, ez, bad);
    n_vec = n_vec + 1;
    if (bad) n_bad = n_bad + 1;
  endtask

  initial begin
    logic fc, fz, fn, fv, fs;
    bit bad;
    // idle state check with zero operands: equal, carry set (R1, R2, R8)
    apply('0, '0, 1'b0);
    // boundary pairs: most negative vs zero, all ones vs zero (R6, R7)
    apply({1'b1, {(W-1){1'b0}}}, '0, 1'b1);
    apply({1'b1, {(W-1){1'b0}}}, '0, 1'b0);
    apply('1, '0, 1'b1);
    apply('0, '1, 1'b0);
    apply({1'b0, {(W-1){1'b1}}}, {1'b1, {(W-1){1'b0}}}, 1'b1);
    // exhaustive sweep in both modes (R1..R8)
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < (1 << W); a++)
        for (int b = 0; b < (1 << W); b++)
          apply(a[W-1:0], b[W-1:0], m[0]);
    // R9: flags unchanged when only the mode toggles
    for (int k = 0; k < 64; k++) begin
      apply(W'(k * 37), W'(k * 91 + 5), 1'b0);
      fc = flag_c; fz = flag_z; fn = flag_n; fv = flag_v; fs = flag_s;
      @(posedge clk);
      signed_mode = 1'b1;
      @(negedge clk);
      bad = 1'b0;
      chk("R9 flag_c", flag_c, fc, bad);
      chk("R9 flag_z", flag_z, fz, bad);
      chk("R9 flag_n", flag_n, fn, bad);
      chk("R9 flag_v", flag_v, fv, bad);
      chk("R9 flag_s", flag_s, fs, bad);
      n_vec = n_vec + 1;
      if (bad) n_bad = n_bad + 1;
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule